// File: doc/BRIEF.md
# Shadowed-Compare Auxiliary PWM Generator

This block drives one PWM pin from a timer. An up-counter is compared with an active period value and an active duty value. Software programs the block through a small memory-mapped register set: a 16-bit control word plus four 32-bit words. Two of the 32-bit words are the active period and duty, and two are shadow copies of them. The control word switches the PWM function on or off, starts or halts the counter, inverts the output sense, and holds a two-bit sync-disable field that is stored for software only.

While the counter is stopped, software writes the active period and duty directly. While it runs, software writes the shadow period and duty instead. A pending flag records that a shadow write has happened, and at the next counter wrap both shadow words are copied into the active pair together. The period in progress therefore always completes with its old values.

Top module: `aux_pwm`

## Requirements
- R1: After reset every register reads zero, the counter is stopped and `pwm_out` is low.
- R2: Byte offsets are 0x08 active period, 0x0C active duty, 0x10 shadow period, 0x14 shadow duty, 0x2A control. Every register reads back what was last written and reads have no side effects. The control register keeps the low 16 bits of a write and returns zeros above them. Bits 7:6 (sync disable) are stored only. Other offsets read zero and writes to them change nothing.
- R3: With control bit 4 set, the counter counts 0,1,…,P and then returns to 0, so a period lasts P+1 cycles. With bit 4 clear the counter holds and the output stays constant.
- R4: With normal sense the output is high while count < D and low otherwise. D=0 gives a constant low output and D>P gives a constant high output. `pwm_out` is registered and lags the count by one cycle.
- R5: Control bit 10 set inverts the output, so D then sets the low time of each period.
- R6: While control bit 9 is clear, `pwm_out` is low whatever the polarity or count.
- R7: Writes to the shadow words leave the active words unchanged until the next wrap. At that wrap both shadow words are copied into the active words, but only if a shadow write has occurred since the last copy.
- R8: If a shadow write lands in the same cycle as a wrap, the wrap copies the shadow contents from before the write and the pending flag stays set. The new value becomes active at the following wrap.
- R9: P=1 with D=1 gives a two-cycle period that is high for one cycle.
- R10: Writes to the active words take effect in the next cycle, both at readback and at the compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable, qualified by bus_sel |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 1 | PWM output |

## Verification
A shadow-register write and a period wrap can fall in the same clock, and they contend for the pending flag and the active duty word. The bench locks onto the output's rising edge to learn the counter's phase. It then counts forward to the last count of the period and issues a shadow-duty write that is captured on exactly the wrapping edge. It reads the active duty register straight after that edge and expects the old value, then reads it again one period later and expects the new value. A separate run measures rise-to-rise spacing and confirms that a shadow update made mid-period does not shorten the current period.

// File: rtl/aux_pwm_pkg.sv
package aux_pwm_pkg;

    localparam int unsigned ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_PER_ACT  = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_DUTY_ACT = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_PER_SHD  = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_DUTY_SHD = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_CTRL     = 6'h2A;

    localparam int unsigned CTL_RUN_BIT  = 4;
    localparam int unsigned CTL_MODE_BIT = 9;
    localparam int unsigned CTL_INV_BIT  = 10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PER_ACT,
        SEL_DUTY_ACT,
        SEL_PER_SHD,
        SEL_DUTY_SHD,
        SEL_CTRL
    } reg_sel_e;

    function automatic reg_sel_e addr_decode(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_PER_ACT:  return SEL_PER_ACT;
            OFS_DUTY_ACT: return SEL_DUTY_ACT;
            OFS_PER_SHD:  return SEL_PER_SHD;
            OFS_DUTY_SHD: return SEL_DUTY_SHD;
            OFS_CTRL:     return SEL_CTRL;
            default:      return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/aux_pwm_regs.sv
module aux_pwm_regs
    import aux_pwm_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CTRL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  reg_sel_e          wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  reg_sel_e          rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wrap,
    output logic [DATA_W-1:0] per_act,
    output logic [DATA_W-1:0] duty_act,
    output logic              run,
    output logic              mode,
    output logic              inv
);

    localparam int unsigned PAD_W = DATA_W - CTRL_W;

    typedef struct packed {
        logic [DATA_W-1:0] per_act;
        logic [DATA_W-1:0] duty_act;
        logic [DATA_W-1:0] per_shd;
        logic [DATA_W-1:0] duty_shd;
        logic [CTRL_W-1:0] ctrl;
        logic              pend;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        // period-boundary transfer of shadows
        if (wrap && q.pend) begin
            d.per_act  = q.per_shd;
            d.duty_act = q.duty_shd;
            d.pend     = 1'b0;
        end
        // bus writes take precedence over the transfer
        case (wr_sel)
            SEL_PER_ACT:  d.per_act  = wr_data;
            SEL_DUTY_ACT: d.duty_act = wr_data;
            SEL_PER_SHD: begin
                d.per_shd = wr_data;
                d.pend    = 1'b1;
            end
            SEL_DUTY_SHD: begin
                d.duty_shd = wr_data;
                d.pend     = 1'b1;
            end
            SEL_CTRL:     d.ctrl = wr_data[CTRL_W-1:0];
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (rd_sel)
            SEL_PER_ACT:  rd_data = q.per_act;
            SEL_DUTY_ACT: rd_data = q.duty_act;
            SEL_PER_SHD:  rd_data = q.per_shd;
            SEL_DUTY_SHD: rd_data = q.duty_shd;
            SEL_CTRL:     rd_data = {{PAD_W{1'b0}}, q.ctrl};
            default:      rd_data = '0;
        endcase
    end

    assign per_act  = q.per_act;
    assign duty_act = q.duty_act;
    assign run      = q.ctrl[CTL_RUN_BIT];
    assign mode     = q.ctrl[CTL_MODE_BIT];
    assign inv      = q.ctrl[CTL_INV_BIT];

    // R7
    shd_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && q.pend && (wr_sel != SEL_PER_ACT) && (wr_sel != SEL_DUTY_ACT))
        |=> (q.per_act == $past(q.per_shd)) && (q.duty_act == $past(q.duty_shd)));

    // R7
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wrap && q.pend) && (wr_sel != SEL_PER_ACT) && (wr_sel != SEL_DUTY_ACT))
        |=> $stable(q.per_act) && $stable(q.duty_act));

    // R8
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && ((wr_sel == SEL_PER_SHD) || (wr_sel == SEL_DUTY_SHD)))
        |=> q.pend);

endmodule

// File: rtl/aux_pwm_timer.sv
module aux_pwm_timer #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DATA_W-1:0] period,
    output logic [DATA_W-1:0] cnt,
    output logic              wrap
);

    typedef struct packed {
        logic [DATA_W-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    assign wrap = run && (q.cnt >= period);

    always_comb begin
        d = q;
        if (run) begin
            if (wrap) d.cnt = '0;
            else      d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt = q.cnt;

    // R3
    cnt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(q.cnt));

    // R3
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (q.cnt == period)) |=> (q.cnt == '0));

endmodule

// File: rtl/aux_pwm_out.sv
module aux_pwm_out #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cnt,
    input  logic [DATA_W-1:0] duty,
    input  logic              mode,
    input  logic              inv,
    output logic              pwm
);

    typedef struct packed {
        logic pwm;
    } out_t;

    out_t q, d;

    always_comb begin
        d     = q;
        d.pwm = mode && ((cnt < duty) ^ inv);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pwm = q.pwm;

    // R6
    mode_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |=> !q.pwm);

    // R4
    duty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && !inv && (duty == '0)) |=> !q.pwm);

endmodule

// File: rtl/aux_pwm.sv
module aux_pwm
    import aux_pwm_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CTRL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out
);

    reg_sel_e          wr_sel;
    reg_sel_e          rd_sel;
    logic [DATA_W-1:0] per_act;
    logic [DATA_W-1:0] duty_act;
    logic [DATA_W-1:0] cnt;
    logic              wrap;
    logic              run;
    logic              mode;
    logic              inv;

    assign rd_sel = addr_decode(bus_addr);
    assign wr_sel = (bus_sel && bus_we) ? rd_sel : SEL_NONE;

    aux_pwm_regs #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sel   (wr_sel),
        .wr_data  (bus_wdata),
        .rd_sel   (rd_sel),
        .rd_data  (bus_rdata),
        .wrap     (wrap),
        .per_act  (per_act),
        .duty_act (duty_act),
        .run      (run),
        .mode     (mode),
        .inv      (inv)
    );

    aux_pwm_timer #(.DATA_W(DATA_W)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .period (per_act),
        .cnt    (cnt),
        .wrap   (wrap)
    );

    aux_pwm_out #(.DATA_W(DATA_W)) out_i (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt),
        .duty  (duty_act),
        .mode  (mode),
        .inv   (inv),
        .pwm   (pwm_out)
    );

endmodule

// File: tb/aux_pwm_tb_top.sv
module aux_pwm_tb_top;

    localparam logic [5:0] A_PA = 6'h08;
    localparam logic [5:0] A_DA = 6'h0C;
    localparam logic [5:0] A_PS = 6'h10;
    localparam logic [5:0] A_DS = 6'h14;
    localparam logic [5:0] A_CT = 6'h2A;

    typedef struct packed {
        logic [31:0] per;
        logic [31:0] duty;
        logic [15:0] ctl;
        logic [31:0] exp;
    } vec_t;

    // ctl: bit4 run, bit9 mode, bit10 invert, bits7:6 sync disable
    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'd9,  32'd3,  16'h02D0, 32'd12},  // R4 normal
        '{32'd9,  32'd3,  16'h06D0, 32'd28},  // R5 inverted
        '{32'd1,  32'd1,  16'h02D0, 32'd4 },  // R9 minimum
        '{32'd7,  32'd0,  16'h02D0, 32'd0 },  // R4 duty zero
        '{32'd7,  32'd20, 16'h02D0, 32'd32},  // R4 duty above period
        '{32'd7,  32'd0,  16'h06D0, 32'd32},  // R5 inverted zero
        '{32'd4,  32'd5,  16'h02D0, 32'd20},  // R4 duty = period+1
        '{32'd15, 32'd8,  16'h02D0, 32'd32},  // R3 longer period
        '{32'd9,  32'd3,  16'h04D0, 32'd0 }   // R6 mode off, inverted
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    aux_pwm dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called just after a falling edge; returns at the next falling edge
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_rise(output int t, output int highs);
        logic prev;
        prev = pwm_out;
        highs = 0;
        t = 0;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            if (!prev && pwm_out) begin
                t = cyc;
                break;
            end
            if (pwm_out) highs++;
            prev = pwm_out;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic        ref_v;
        logic        bad;
        int          highs;
        int          win;
        int          ta, tb, tc, h;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_PA, r); chk("R1 per_act", r, 0);
        rd(A_DA, r); chk("R1 duty_act", r, 0);
        rd(A_PS, r); chk("R1 per_shd", r, 0);
        rd(A_DS, r); chk("R1 duty_shd", r, 0);
        rd(A_CT, r); chk("R1 ctrl", r, 0);
        chk("R1 pwm_out", {31'd0, pwm_out}, 0);

        // R2 readback, R10 direct active write
        wr(A_PA, 32'hDEADBEEF);
        wr(A_DA, 32'h12345678);
        wr(A_PS, 32'hCAFEF00D);
        wr(A_DS, 32'h0BADF00D);
        wr(A_CT, 32'hFFFF0000);
        rd(A_PA, r); chk("R2 R10 per_act", r, 32'hDEADBEEF);
        rd(A_DA, r); chk("R2 R10 duty_act", r, 32'h12345678);
        rd(A_PS, r); chk("R2 per_shd", r, 32'hCAFEF00D);
        rd(A_DS, r); chk("R2 duty_shd", r, 32'h0BADF00D);
        wr(A_CT, 32'hABCD00C0);
        rd(A_CT, r); chk("R2 ctrl low 16 bits", r, 32'h000000C0);
        // R2 unmapped offset
        wr(6'h20, 32'hFFFFFFFF);
        rd(6'h20, r); chk("R2 unmapped read", r, 0);
        rd(A_PA, r); chk("R2 unmapped write ignored", r, 32'hDEADBEEF);

        // vector table: R3 R4 R5 R6 R9 R10
        for (int i = 0; i < NV; i++) begin
            wr(A_CT, 32'h0);
            wr(A_PA, VECS[i].per);
            wr(A_DA, VECS[i].duty);
            wr(A_PS, VECS[i].per);
            wr(A_DS, VECS[i].duty);
            wr(A_CT, {16'h0, VECS[i].ctl});
            repeat (VECS[i].per + 3) @(negedge clk);
            win = 4 * (int'(VECS[i].per) + 1);
            highs = 0;
            for (int k = 0; k < win; k++) begin
                if (pwm_out) highs++;
                @(negedge clk);
            end
            chk($sformatf("R3 R4 R5 R6 R9 vector %0d high count", i), highs, VECS[i].exp);
        end

        // R3 counter halt freezes output
        wr(A_CT, 32'h0210);
        repeat (12) @(negedge clk);
        wr(A_CT, 32'h0200);
        @(negedge clk);
        ref_v = pwm_out;
        bad = 1'b0;
        repeat (30) begin
            @(negedge clk);
            if (pwm_out !== ref_v) bad = 1'b1;
        end
        chk("R3 halted output stable", {31'd0, bad}, 0);

        // R7 shadow update mid-period
        wr(A_CT, 32'h0);
        wr(A_PA, 32'd9);
        wr(A_DA, 32'd5);
        wr(A_PS, 32'd9);
        wr(A_DS, 32'd5);
        wr(A_CT, 32'h0210);
        repeat (12) @(negedge clk);
        wait_rise(ta, h);
        wr(A_PS, 32'd3);
        wr(A_DS, 32'd2);
        rd(A_PA, r); chk("R7 active period held", r, 32'd9);
        wait_rise(tb, h);
        chk("R7 current period completes", tb - ta, 10);
        rd(A_PA, r); chk("R7 period copied at wrap", r, 32'd3);
        wait_rise(tc, h);
        chk("R7 new period length", tc - tb, 4);
        chk("R7 new duty high cycles after rise", h, 1);

        // R8 shadow write in the wrap cycle
        wr(A_CT, 32'h0);
        wr(A_PA, 32'd5);
        wr(A_DA, 32'd2);
        wr(A_PS, 32'd5);
        wr(A_DS, 32'd2);
        wr(A_CT, 32'h0210);
        repeat (8) @(negedge clk);
        wait_rise(ta, h);
        repeat (4) @(negedge clk);
        wr(A_DS, 32'd4);
        rd(A_DA, r); chk("R8 old shadow copied at collision", r, 32'd2);
        repeat (6) @(negedge clk);
        rd(A_DA, r); chk("R8 new duty at following wrap", r, 32'd4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule